// File: doc/BRIEF.md
# Register Rename Unit with Branch Checkpoints

This block maps the architectural register names of a small group of decoded instructions onto physical registers for an out-of-order core. In one cycle it looks up the physical register behind each source operand and takes a fresh physical register from a free pool for each destination. It also reports the mapping that each destination replaces. The speculative map table holds the state after every renamed instruction. A separate committed map holds only the state of retired instructions. When the commit port retires a destination, the map that was replaced goes back to the pool.

Dependences between instructions of the same group are resolved inside the block. A later slot that reads or writes a logical register written by an earlier slot sees that slot's new physical register. A group may carry a branch, which saves a snapshot of both the speculative map and the free pool. Snapshots sit in a shift structure, oldest first, and branches resolve in program order. A mispredicted branch rolls the speculative state back to its snapshot. An exception rolls it back to the committed map and frees every register that the committed map does not hold.

Top module: `rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical register i in both maps, and the physical registers from NUM_LOG upward form the free pool.
- R2: Each source output carries the speculative mapping of its logical source, and each old-mapping output carries the speculative mapping of its logical destination. Both are taken before the group is applied.
- R3: In a group, a source or destination of slot j that names a logical register written by an earlier slot k<j (with its destination valid) takes the new physical register of the latest such k.
- R4: Destinations are handed out in slot order. Each valid slot receives the lowest-numbered physical register still free. Slots without a valid destination take none, and no register is given twice.
- R5: `ren_ready` is low when the pool holds fewer free registers than the group has valid destinations, or when the group carries a branch and all NUM_CKPT snapshots are in use. A group presented while ready is low changes no state.
- R6: A commit writes its physical register into the committed map at its logical index. It returns its old physical register to the pool, and that register can be allocated in the next cycle.
- R7: A group with `ren_branch` saves the speculative map and free pool as they stand after the group. A correct resolve discards the oldest snapshot.
- R8: A mispredicted resolve restores the speculative map and free pool from the oldest snapshot. Registers released by commits since that snapshot stay free. All snapshots are then dropped.
- R9: An exception flush copies the committed map into the speculative map, makes free every physical register that the committed map does not hold, and drops all snapshots.
- R10: During a cycle with a recovery, `ren_ready` is low and no group is renamed. A commit in the same cycle is applied before the recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ren_valid | input | 1 | A rename group is presented |
| ren_dst_valid | input | GROUP | Per slot: the slot writes a destination |
| ren_dst | input | GROUP*LW | Logical destinations, slot 0 in the low bits |
| ren_src1 | input | GROUP*LW | First logical sources |
| ren_src2 | input | GROUP*LW | Second logical sources |
| ren_branch | input | 1 | Group ends with a branch: take a snapshot |
| ren_ready | output | 1 | Group can be renamed this cycle |
| ren_psrc1 | output | GROUP*PW | Physical first sources |
| ren_psrc2 | output | GROUP*PW | Physical second sources |
| ren_pdst | output | GROUP*PW | Newly allocated physical destinations |
| ren_pold | output | GROUP*PW | Physical registers replaced by each destination |
| cmt_valid | input | 1 | Retire one destination |
| cmt_ldst | input | LW | Logical register being retired |
| cmt_pdst | input | PW | Its physical register |
| cmt_pold | input | PW | Physical register it replaced, to be freed |
| br_resolve | input | 1 | Oldest outstanding branch resolves |
| br_mispredict | input | 1 | With br_resolve: the branch was mispredicted |
| exc_flush | input | 1 | Roll back to the committed state |

## Verification
The hardest situation to reach is a mispredict whose snapshot has to be merged with registers freed after it was taken. The bench reaches it by retiring only instructions older than the oldest unresolved branch, while new branch groups and commits keep arriving. Running out of registers and filling every checkpoint happen by themselves, because the pool holds only four spare registers. The bench keeps a behavioural model in arrays, with a reorder list of renamed destinations and their sequence numbers. This model drives commits that stay consistent and drops squashed entries on each recovery.

// File: rtl/rn_pkg.sv
package rn_pkg;

   typedef enum logic [1:0] {
      RCV_NONE   = 2'd0,
      RCV_BRANCH = 2'd1,
      RCV_EXCEPT = 2'd2
   } recover_e;

endpackage

// File: rtl/rn_freelist.sv
module rn_freelist
   import rn_pkg::*;
#(
   parameter int NUM_LOG  = 6,
   parameter int NUM_PHYS = 10,
   parameter int GROUP    = 2,
   parameter int PW       = 4,
   parameter int CW       = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          fire,
   input  logic [GROUP-1:0]              dst_valid,
   input  logic                          rel_valid,
   input  logic [PW-1:0]                 rel_id,
   input  recover_e                      rcv,
   input  logic [NUM_PHYS-1:0]           cmap_used,
   input  logic [NUM_PHYS-1:0]           snap_free,
   output logic [GROUP-1:0][PW-1:0]      alloc_id,
   output logic [CW-1:0]                 free_cnt,
   output logic [NUM_PHYS-1:0]           rel_mask,
   output logic [NUM_PHYS-1:0]           free_q,
   output logic [NUM_PHYS-1:0]           free_post
);

   logic [NUM_PHYS-1:0] avail;
   logic [NUM_PHYS-1:0] free_d;

   // lowest-numbered free register per slot, consumed in slot order
   always_comb begin
      avail = free_q;
      for (int s = 0; s < GROUP; s++) begin
         alloc_id[s] = '0;
         for (int p = NUM_PHYS - 1; p >= 0; p--) begin
            if (avail[p]) alloc_id[s] = PW'(p);
         end
         if (dst_valid[s]) avail[alloc_id[s]] = 1'b0;
      end
   end

   always_comb begin
      rel_mask = '0;
      if (rel_valid) rel_mask[rel_id] = 1'b1;
   end

   assign free_post = (fire ? avail : free_q) | rel_mask;
   assign free_cnt  = CW'($countones(free_q));

   always_comb begin
      unique case (rcv)
         RCV_EXCEPT: free_d = ~cmap_used;
         RCV_BRANCH: free_d = snap_free | rel_mask;
         default:    free_d = free_post;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_PHYS; p++) free_q[p] <= (p >= NUM_LOG);
      end else begin
         free_q <= free_d;
      end
   end

endmodule

// File: rtl/rn_specmap.sv
module rn_specmap
   import rn_pkg::*;
#(
   parameter int NUM_LOG = 6,
   parameter int GROUP   = 2,
   parameter int LW      = 3,
   parameter int PW      = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          fire,
   input  logic [GROUP-1:0]              dst_valid,
   input  logic [GROUP-1:0][LW-1:0]      dst,
   input  logic [GROUP-1:0][LW-1:0]      src1,
   input  logic [GROUP-1:0][LW-1:0]      src2,
   input  logic [GROUP-1:0][PW-1:0]      alloc_id,
   input  recover_e                      rcv,
   input  logic [NUM_LOG-1:0][PW-1:0]    cmap_nxt,
   input  logic [NUM_LOG-1:0][PW-1:0]    snap_map,
   output logic [GROUP-1:0][PW-1:0]      psrc1,
   output logic [GROUP-1:0][PW-1:0]      psrc2,
   output logic [GROUP-1:0][PW-1:0]      pold,
   output logic [NUM_LOG-1:0][PW-1:0]    map_q,
   output logic [NUM_LOG-1:0][PW-1:0]    map_post
);

   logic [NUM_LOG-1:0][PW-1:0] walk;
   logic [NUM_LOG-1:0][PW-1:0] map_d;

   // slots walk the map in order so later slots see earlier writes
   always_comb begin
      walk = map_q;
      for (int s = 0; s < GROUP; s++) begin
         psrc1[s] = walk[src1[s]];
         psrc2[s] = walk[src2[s]];
         pold[s]  = walk[dst[s]];
         if (dst_valid[s]) walk[dst[s]] = alloc_id[s];
      end
      map_post = walk;
   end

   always_comb begin
      unique case (rcv)
         RCV_EXCEPT: map_d = cmap_nxt;
         RCV_BRANCH: map_d = snap_map;
         default:    map_d = fire ? map_post : map_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < NUM_LOG; l++) map_q[l] <= PW'(l);
      end else begin
         map_q <= map_d;
      end
   end

endmodule

// File: rtl/rn_ckpt.sv
module rn_ckpt #(
   parameter int NUM_LOG  = 6,
   parameter int NUM_PHYS = 10,
   parameter int PW       = 4,
   parameter int NUM_CKPT = 2,
   parameter int KW       = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push,
   input  logic [NUM_LOG-1:0][PW-1:0]    push_map,
   input  logic [NUM_PHYS-1:0]           push_free,
   input  logic                          pop,
   input  logic                          clear,
   input  logic [NUM_PHYS-1:0]           rel_mask,
   output logic [NUM_LOG-1:0][PW-1:0]    head_map,
   output logic [NUM_PHYS-1:0]           head_free,
   output logic [KW-1:0]                 cnt_q
);

   logic [NUM_LOG-1:0][PW-1:0] map_q  [NUM_CKPT];
   logic [NUM_LOG-1:0][PW-1:0] map_d  [NUM_CKPT];
   logic [NUM_PHYS-1:0]        free_q [NUM_CKPT];
   logic [NUM_PHYS-1:0]        free_d [NUM_CKPT];
   logic [KW-1:0]              cnt_d;

   // slot 0 holds the oldest snapshot; entries shift down on resolve
   always_comb begin
      cnt_d = cnt_q;
      for (int k = 0; k < NUM_CKPT; k++) begin
         map_d[k]  = map_q[k];
         free_d[k] = free_q[k] | rel_mask;
      end
      if (clear) begin
         cnt_d = '0;
      end else begin
         if (pop && (cnt_q != '0)) begin
            for (int k = 0; k < NUM_CKPT - 1; k++) begin
               map_d[k]  = map_d[k+1];
               free_d[k] = free_d[k+1];
            end
            cnt_d = cnt_d - KW'(1);
         end
         if (push && (cnt_d < KW'(NUM_CKPT))) begin
            map_d[cnt_d]  = push_map;
            free_d[cnt_d] = push_free;
            cnt_d         = cnt_d + KW'(1);
         end
      end
   end

   for (genvar k = 0; k < NUM_CKPT; k++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            map_q[k]  <= '0;
            free_q[k] <= '0;
         end else begin
            map_q[k]  <= map_d[k];
            free_q[k] <= free_d[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign head_map  = map_q[0];
   assign head_free = free_q[0];

endmodule

// File: rtl/rename_unit.sv
module rename_unit
   import rn_pkg::*;
#(
   parameter int NUM_LOG  = 6,
   parameter int NUM_PHYS = 10,
   parameter int GROUP    = 2,
   parameter int NUM_CKPT = 2,
   localparam int LW      = (NUM_LOG  > 1) ? $clog2(NUM_LOG)  : 1,
   localparam int PW      = (NUM_PHYS > 1) ? $clog2(NUM_PHYS) : 1,
   localparam int CW      = $clog2(NUM_PHYS + 1),
   localparam int KW      = $clog2(NUM_CKPT + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ren_valid,
   input  logic [GROUP-1:0]      ren_dst_valid,
   input  logic [GROUP*LW-1:0]   ren_dst,
   input  logic [GROUP*LW-1:0]   ren_src1,
   input  logic [GROUP*LW-1:0]   ren_src2,
   input  logic                  ren_branch,
   output logic                  ren_ready,
   output logic [GROUP*PW-1:0]   ren_psrc1,
   output logic [GROUP*PW-1:0]   ren_psrc2,
   output logic [GROUP*PW-1:0]   ren_pdst,
   output logic [GROUP*PW-1:0]   ren_pold,
   input  logic                  cmt_valid,
   input  logic [LW-1:0]         cmt_ldst,
   input  logic [PW-1:0]         cmt_pdst,
   input  logic [PW-1:0]         cmt_pold,
   input  logic                  br_resolve,
   input  logic                  br_mispredict,
   input  logic                  exc_flush
);

   if (NUM_PHYS < NUM_LOG + GROUP) begin : g_bad_phys
      $error("rename_unit: NUM_PHYS must cover NUM_LOG plus one group");
   end
   if (NUM_CKPT < 1 || GROUP < 1) begin : g_bad_count
      $error("rename_unit: NUM_CKPT and GROUP must be at least 1");
   end

   logic [GROUP-1:0][LW-1:0]   dst_a, src1_a, src2_a;
   logic [GROUP-1:0][PW-1:0]   psrc1_a, psrc2_a, pold_a, alloc_a;
   logic [NUM_LOG-1:0][PW-1:0] map_q, map_post, snap_map;
   logic [NUM_LOG-1:0][PW-1:0] cmap_q, cmap_nxt;
   logic [NUM_PHYS-1:0]        cmap_used, free_q, free_post, snap_free, rel_mask;
   logic [CW-1:0]              free_cnt, need_cnt;
   logic [KW-1:0]              ck_cnt;
   logic                       fire, recovering;
   recover_e                   rcv;

   assign dst_a     = ren_dst;
   assign src1_a    = ren_src1;
   assign src2_a    = ren_src2;
   assign ren_psrc1 = psrc1_a;
   assign ren_psrc2 = psrc2_a;
   assign ren_pold  = pold_a;
   assign ren_pdst  = alloc_a;

   always_comb begin
      if (exc_flush)                                        rcv = RCV_EXCEPT;
      else if (br_resolve && br_mispredict && ck_cnt != '0) rcv = RCV_BRANCH;
      else                                                  rcv = RCV_NONE;
   end
   assign recovering = (rcv != RCV_NONE);

   assign need_cnt  = CW'($countones(ren_dst_valid));
   assign ren_ready = !recovering && (free_cnt >= need_cnt) &&
                      !(ren_branch && ck_cnt == KW'(NUM_CKPT));
   assign fire      = ren_valid && ren_ready;

   // committed map: retire order, applied before any recovery this cycle
   always_comb begin
      cmap_nxt = cmap_q;
      if (cmt_valid) cmap_nxt[cmt_ldst] = cmt_pdst;
      cmap_used = '0;
      for (int l = 0; l < NUM_LOG; l++) cmap_used[cmap_nxt[l]] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < NUM_LOG; l++) cmap_q[l] <= PW'(l);
      end else begin
         cmap_q <= cmap_nxt;
      end
   end

   rn_freelist #(
      .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .GROUP(GROUP), .PW(PW), .CW(CW)
   ) u_free (
      .clk(clk), .rst_n(rst_n), .fire(fire), .dst_valid(ren_dst_valid),
      .rel_valid(cmt_valid), .rel_id(cmt_pold), .rcv(rcv),
      .cmap_used(cmap_used), .snap_free(snap_free), .alloc_id(alloc_a),
      .free_cnt(free_cnt), .rel_mask(rel_mask), .free_q(free_q),
      .free_post(free_post)
   );

   rn_specmap #(
      .NUM_LOG(NUM_LOG), .GROUP(GROUP), .LW(LW), .PW(PW)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .fire(fire), .dst_valid(ren_dst_valid),
      .dst(dst_a), .src1(src1_a), .src2(src2_a), .alloc_id(alloc_a),
      .rcv(rcv), .cmap_nxt(cmap_nxt), .snap_map(snap_map),
      .psrc1(psrc1_a), .psrc2(psrc2_a), .pold(pold_a),
      .map_q(map_q), .map_post(map_post)
   );

   rn_ckpt #(
      .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .PW(PW),
      .NUM_CKPT(NUM_CKPT), .KW(KW)
   ) u_ckpt (
      .clk(clk), .rst_n(rst_n), .push(fire && ren_branch),
      .push_map(map_post), .push_free(free_post),
      .pop(br_resolve && !br_mispredict), .clear(recovering),
      .rel_mask(rel_mask), .head_map(snap_map), .head_free(snap_free),
      .cnt_q(ck_cnt)
   );

endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
   parameter int NUM_LOG  = 6,
   parameter int NUM_PHYS = 10,
   parameter int GROUP    = 2,
   parameter int NUM_CKPT = 2,
   parameter int LW       = 3,
   parameter int PW       = 4,
   parameter int KW       = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       ren_valid,
   input logic                       ren_ready,
   input logic                       fire,
   input logic                       exc_flush,
   input logic [GROUP-1:0]           ren_dst_valid,
   input logic [GROUP*LW-1:0]        ren_dst,
   input logic [GROUP*LW-1:0]        ren_src1,
   input logic [GROUP*PW-1:0]        ren_psrc1,
   input logic [GROUP*PW-1:0]        ren_pdst,
   input logic [NUM_PHYS-1:0]        free_q,
   input logic [NUM_LOG-1:0][PW-1:0] cmap_q,
   input logic [NUM_LOG-1:0][PW-1:0] map_q,
   input logic [KW-1:0]              ck_cnt
);

   logic [NUM_PHYS-1:0] held;
   always_comb begin
      held = '0;
      for (int l = 0; l < NUM_LOG; l++) held[cmap_q[l]] = 1'b1;
   end

   p_alloc_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fire && ren_dst_valid[0] |-> free_q[ren_pdst[PW-1:0]]);

   p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ren_valid && ($countones(free_q) < $countones(ren_dst_valid)) |-> !ren_ready);

   p_pool_disjoint_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (free_q & held) == '0);

   p_ckpt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ck_cnt <= KW'(NUM_CKPT));

   p_except_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      exc_flush |=> (map_q == cmap_q));

   if (GROUP >= 2) begin : g_pair
      p_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
         fire && ren_dst_valid[0] && ren_dst_valid[1] |->
         ren_pdst[PW-1:0] != ren_pdst[2*PW-1:PW]);

      p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
         fire && ren_dst_valid[0] && (ren_src1[2*LW-1:LW] == ren_dst[LW-1:0]) |->
         ren_psrc1[2*PW-1:PW] == ren_pdst[PW-1:0]);
   end

endmodule

bind rename_unit rn_checker #(
   .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .GROUP(GROUP),
   .NUM_CKPT(NUM_CKPT), .LW(LW), .PW(PW), .KW(KW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
   .fire(fire), .exc_flush(exc_flush), .ren_dst_valid(ren_dst_valid),
   .ren_dst(ren_dst), .ren_src1(ren_src1), .ren_psrc1(ren_psrc1),
   .ren_pdst(ren_pdst), .free_q(free_q), .cmap_q(cmap_q), .map_q(map_q),
   .ck_cnt(ck_cnt)
);

// File: tb/rename_unit_tb.sv
module rename_unit_tb;

   localparam int NL = 6, NP = 10, G = 2, NC = 2, LW = 3, PW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5ns clk = ~clk;

   logic          b_v, b_br, b_cmt, b_res, b_mis, b_exc;
   logic [G-1:0]  b_dv;
   logic [LW-1:0] b_dst [G];
   logic [LW-1:0] b_s1  [G];
   logic [LW-1:0] b_s2  [G];
   logic [LW-1:0] b_cl;
   logic [PW-1:0] b_cp, b_co;

   logic            ren_ready;
   logic [G*PW-1:0] ren_psrc1, ren_psrc2, ren_pdst, ren_pold;

   rename_unit u_dut (
      .clk(clk), .rst_n(rst_n), .ren_valid(b_v), .ren_dst_valid(b_dv),
      .ren_dst({b_dst[1], b_dst[0]}), .ren_src1({b_s1[1], b_s1[0]}),
      .ren_src2({b_s2[1], b_s2[0]}), .ren_branch(b_br), .ren_ready(ren_ready),
      .ren_psrc1(ren_psrc1), .ren_psrc2(ren_psrc2), .ren_pdst(ren_pdst),
      .ren_pold(ren_pold), .cmt_valid(b_cmt), .cmt_ldst(b_cl), .cmt_pdst(b_cp),
      .cmt_pold(b_co), .br_resolve(b_res), .br_mispredict(b_mis),
      .exc_flush(b_exc)
   );

   int nchk = 0, nfail = 0;
   bit done = 0;
   string ctx = "R1";

   // behavioural reference state
   int mm [NL];
   int cm [NL];
   bit mf [NP];
   int ckm [NC][NL];
   bit ckf [NC][NP];
   int cks [NC];
   int ckn = 0;
   int rob_l [16], rob_p [16], rob_o [16], rob_s [16];
   int rob_n = 0, seq = 0;

   task automatic chk(string req, string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int fld(logic [G*PW-1:0] v, int s);
      return int'(v[s*PW +: PW]);
   endfunction

   task automatic idle();
      b_v = 0; b_br = 0; b_cmt = 0; b_res = 0; b_mis = 0; b_exc = 0;
      b_dv = '0; b_cl = '0; b_cp = '0; b_co = '0;
      for (int s = 0; s < G; s++) begin
         b_dst[s] = '0; b_s1[s] = '0; b_s2[s] = '0;
      end
   endtask

   task automatic rob_pop();
      for (int i = 0; i < 15; i++) begin
         rob_l[i] = rob_l[i+1]; rob_p[i] = rob_p[i+1];
         rob_o[i] = rob_o[i+1]; rob_s[i] = rob_s[i+1];
      end
      rob_n--;
   endtask

   // compare outputs for the current inputs, then advance the model one edge
   task automatic step();
      int t [NL];
      bit av [NP];
      int pd [G];
      int ps1 [G], ps2 [G], po [G];
      bit by1 [G], by2 [G], byo [G];
      int fc, nd;
      bit rec, rdy, fire, mis_ok;
      string nctx;
      fc = 0; nd = 0;
      for (int p = 0; p < NP; p++) fc += int'(mf[p]);
      for (int s = 0; s < G; s++) nd += int'(b_dv[s]);
      mis_ok = b_res && b_mis && ckn > 0;
      rec  = b_exc || mis_ok;
      rdy  = !rec && fc >= nd && !(b_br && ckn == NC);
      fire = b_v && rdy;
      for (int l = 0; l < NL; l++) t[l] = mm[l];
      for (int p = 0; p < NP; p++) av[p] = mf[p];
      for (int s = 0; s < G; s++) begin
         pd[s] = 0;
         for (int p = NP - 1; p >= 0; p--) if (av[p]) pd[s] = p;
         by1[s] = 0; by2[s] = 0; byo[s] = 0;
         for (int k = 0; k < s; k++) begin
            if (b_dv[k] && b_dst[k] == b_s1[s])  by1[s] = 1;
            if (b_dv[k] && b_dst[k] == b_s2[s])  by2[s] = 1;
            if (b_dv[k] && b_dst[k] == b_dst[s]) byo[s] = 1;
         end
         ps1[s] = t[b_s1[s]];
         ps2[s] = t[b_s2[s]];
         po[s]  = t[b_dst[s]];
         if (b_dv[s]) begin
            av[pd[s]] = 0;
            t[b_dst[s]] = pd[s];
         end
      end
      #1ns;
      chk(rec ? "R10" : "R5", "ready", int'(ren_ready), int'(rdy));
      if (fire) begin
         for (int s = 0; s < G; s++) begin
            chk(by1[s] ? "R3" : {ctx, "/R2"}, "psrc1", fld(ren_psrc1, s), ps1[s]);
            chk(by2[s] ? "R3" : {ctx, "/R2"}, "psrc2", fld(ren_psrc2, s), ps2[s]);
            if (b_dv[s]) begin
               chk({ctx, "/R4"}, "pdst", fld(ren_pdst, s), pd[s]);
               chk(byo[s] ? "R3" : {ctx, "/R2"}, "pold", fld(ren_pold, s), po[s]);
            end
         end
      end
      // advance reference state
      if (b_exc)                 nctx = "R9";
      else if (mis_ok)           nctx = "R8";
      else if (b_res || (fire && b_br)) nctx = "R7";
      else if (b_cmt)            nctx = "R6";
      else                       nctx = "R2";
      if (rec && b_cmt) nctx = {nctx, "/R10"};
      if (b_cmt) begin
         cm[b_cl] = int'(b_cp);
         rob_pop();
      end
      if (b_exc) begin
         for (int l = 0; l < NL; l++) mm[l] = cm[l];
         for (int p = 0; p < NP; p++) mf[p] = 1;
         for (int l = 0; l < NL; l++) mf[cm[l]] = 0;
         ckn = 0; rob_n = 0;
      end else if (mis_ok) begin
         while (rob_n > 0 && rob_s[rob_n-1] >= cks[0]) rob_n--;
         for (int l = 0; l < NL; l++) mm[l] = ckm[0][l];
         for (int p = 0; p < NP; p++) mf[p] = ckf[0][p];
         if (b_cmt) mf[b_co] = 1;
         ckn = 0;
      end else begin
         if (fire) begin
            for (int l = 0; l < NL; l++) mm[l] = t[l];
            for (int p = 0; p < NP; p++) mf[p] = av[p];
            for (int s = 0; s < G; s++) if (b_dv[s]) begin
               rob_l[rob_n] = int'(b_dst[s]); rob_p[rob_n] = pd[s];
               rob_o[rob_n] = po[s]; rob_s[rob_n] = seq;
               rob_n++; seq++;
            end
         end
         if (b_cmt) begin
            mf[b_co] = 1;
            for (int k = 0; k < ckn; k++) ckf[k][b_co] = 1;
         end
         if (b_res && ckn > 0) begin
            for (int k = 0; k < NC - 1; k++) begin
               cks[k] = cks[k+1];
               for (int l = 0; l < NL; l++) ckm[k][l] = ckm[k+1][l];
               for (int p = 0; p < NP; p++) ckf[k][p] = ckf[k+1][p];
            end
            ckn--;
         end
         if (fire && b_br && ckn < NC) begin
            for (int l = 0; l < NL; l++) ckm[ckn][l] = mm[l];
            for (int p = 0; p < NP; p++) ckf[ckn][p] = mf[p];
            cks[ckn] = seq;
            ckn++;
         end
      end
      ctx = nctx;
      @(negedge clk);
   endtask

   task automatic gen();
      idle();
      b_v = ($urandom % 10) < 8;
      for (int s = 0; s < G; s++) begin
         b_dv[s]  = ($urandom % 3) != 0;
         b_dst[s] = LW'($urandom % NL);
         b_s1[s]  = LW'($urandom % NL);
         b_s2[s]  = LW'($urandom % NL);
      end
      b_br = ($urandom % 6) == 0;
      if (rob_n > 0 && (ckn == 0 || rob_s[0] < cks[0]) && ($urandom % 2) == 0) begin
         b_cmt = 1;
         b_cl  = LW'(rob_l[0]);
         b_cp  = PW'(rob_p[0]);
         b_co  = PW'(rob_o[0]);
      end
      b_res = ckn > 0 && ($urandom % 5) == 0;
      b_mis = ($urandom % 3) == 0;
      b_exc = ($urandom % 40) == 0;
   endtask

   initial begin
      for (int l = 0; l < NL; l++) begin mm[l] = l; cm[l] = l; end
      for (int p = 0; p < NP; p++) mf[p] = (p >= NL);
      void'($urandom(32'd11));
      idle();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset map and pool, with in-group bypass from slot 0
      b_v = 1; b_dv = 2'b11;
      b_dst[0] = 3'd2; b_s1[0] = 3'd4; b_s2[0] = 3'd5;
      b_dst[1] = 3'd3; b_s1[1] = 3'd2; b_s2[1] = 3'd3;
      #1ns;
      chk("R1", "reset psrc1", fld(ren_psrc1, 0), 4);
      chk("R1", "reset psrc2", fld(ren_psrc2, 0), 5);
      chk("R1", "first pdst", fld(ren_pdst, 0), 6);
      chk("R1", "second pdst", fld(ren_pdst, 1), 7);
      chk("R1", "reset pold", fld(ren_pold, 0), 2);
      chk("R3", "bypass psrc1", fld(ren_psrc1, 1), 6);
      step();
      // exhaust the pool: second group takes 8 and 9
      b_dst[0] = 3'd0; b_dst[1] = 3'd1;
      step();
      b_dv = 2'b01;
      #1ns;
      chk("R5", "ready with empty pool", int'(ren_ready), 0);
      step();
      // exception flush back to the committed state
      idle(); b_exc = 1;
      step();
      idle(); b_v = 1; b_dv = 2'b01; b_dst[0] = 3'd2; b_s1[0] = 3'd2;
      #1ns;
      chk("R9", "psrc after flush", fld(ren_psrc1, 0), 2);
      step();
      for (int i = 0; i < 6000; i++) begin
         gen();
         step();
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      #1ms;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

endmodule